// File: doc/BRIEF.md
# PCI Type-0 Configuration Header Register File

This block holds the 64-byte type-0 configuration header of a PCI function. A requester presents a byte offset, an access width of one, two or four bytes, a direction flag and write data. One cycle after the request is taken the block returns a single response pulse, with read data and an error flag. Identification fields, class code, header type and the other fixed fields come from parameters. Command, cache line size, latency timer, interrupt line, expansion ROM base and the six base address registers can be written.

Each of the six base address registers has its own power-of-two window size and a space type, either I/O or memory. Software finds a window's size by writing all ones and reading back a mask. Software then maps the window by writing an address. A mapped window raises its enable output and exports its base address, offset by a per-space base parameter, so that address-match logic outside this block can decode it. Every window size must be zero or a power of two, and elaboration fails with an error when one is not.

Top module: `cfg_header_regs`

## Requirements
- R1: `req_ready` is high whenever no response is pending. A request taken on a clock edge (`req_valid` and `req_ready` both high) produces `resp_valid` high for exactly the following cycle, and `req_ready` is low during that cycle.
- R2: After reset, every field holds its parameter default. A BAR reads its type bits only (I/O: 0x00000001, memory: 0x00000000), all `bar_en_o` bits are 0 and every exported base is 0.
- R3: A `req_size` other than 1, 2 or 4 sets `resp_err`, returns read data 0 and changes no register and no exported output.
- R4: An offset of 0x40 or above sets `resp_err`. A 2-byte access at an odd offset and a 4-byte access at an offset that is not a multiple of 4 also set `resp_err`. None of these changes any state.
- R5: Reads are little-endian. The byte at the offset lands in bits [7:0], the next byte in [15:8], and so on. The dword layout is fixed: 0x00 {device, vendor}; 0x04 {status, command}; 0x08 {class, subclass, prog-if, revision}; 0x0C {BIST, header type, latency timer, cache line}; 0x10–0x24 BAR0–BAR5; 0x28 cardbus pointer; 0x2C {subsystem id, subsystem vendor}; 0x30 ROM base; 0x34 and 0x38 read 0; 0x3C {max latency, min grant, interrupt pin, interrupt line}.
- R6: A 1-byte write stores into offsets 0x0C, 0x0D and 0x3C. It is accepted with no effect at 0x08, 0x0B, 0x3D, 0x3E and 0x3F. At any other offset it sets `resp_err`.
- R7: A 2-byte write at 0x04 loads the command register. A 2-byte write at any other offset sets `resp_err`.
- R8: A 4-byte write at 0x04 loads the command register from bits [15:0] and leaves status unchanged. A 4-byte write to a dword that is not 0x04, a BAR or 0x30 is accepted without error and has no effect.
- R9: A 4-byte write of 0xFFFFFFFF to a BAR sets its address bits to ~(size−1) and keeps its type bits. A BAR of size 0 then reads its type bits only.
- R10: Any other 4-byte BAR write stores the written value in the address bits and keeps the old type bits. The type mask is bits [1:0] for I/O BARs and bits [3:0] for memory BARs.
- R11: A non-probe BAR write whose address bits are nonzero sets that BAR's `bar_en_o` bit. It also sets its exported base to the address bits plus `IO_BASE` (I/O) or `MEM_BASE` (memory). Probe writes and writes with zero address bits leave the enable and the base unchanged. An enable stays set until reset.
- R12: A 4-byte write of 0xFFFFFFFE to 0x30 makes the ROM base read 0xFFFFFFFF. Any other value is stored as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 8 | Byte offset into configuration space |
| req_size | input | 3 | Access width in bytes (1, 2 or 4 legal) |
| req_wdata | input | 32 | Write data, least significant byte at the offset |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_rdata | output | 32 | Read data, 0 on writes and errors |
| resp_err | output | 1 | Request rejected |
| bar_en_o | output | 6 | Per-BAR mapped flag |
| bar_base_o | output | 192 | Per-BAR exported base, BAR k in bits [32k+31:32k] |

## Verification
The bench goes after the places where the decode is easy to get wrong. It sweeps every offset and width through all eight size codes, including the boundary at 0x40 and every misalignment. A decoder that falls through between byte registers, or accepts a two-byte write outside the command register, shows up as a corrupted neighbour byte or a missing error. Probe and map writes are applied to every BAR, including the unused size-zero one and both I/O BARs, and then to a mapped BAR that gets zero or all ones. A design that mixes up the two type masks, lets the type bits be overwritten, or clears or moves an enable on those writes reads back the wrong bits or exports the wrong base. The ROM probe value and its one-bit neighbours check that only the exact pattern is turned into all ones.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

  localparam int NUM_BARS  = 6;
  localparam int HDR_DW    = 16;
  localparam logic [7:0] HDR_LIMIT  = 8'h40;

  localparam logic [7:0] OFS_CMD     = 8'h04;
  localparam logic [7:0] OFS_REV     = 8'h08;
  localparam logic [7:0] OFS_CLASS   = 8'h0B;
  localparam logic [7:0] OFS_CLS     = 8'h0C;
  localparam logic [7:0] OFS_LAT     = 8'h0D;
  localparam logic [7:0] OFS_BAR0    = 8'h10;
  localparam logic [7:0] OFS_ROM     = 8'h30;
  localparam logic [7:0] OFS_INTLINE = 8'h3C;
  localparam logic [7:0] OFS_INTPIN  = 8'h3D;
  localparam logic [7:0] OFS_MINGNT  = 8'h3E;
  localparam logic [7:0] OFS_MAXLAT  = 8'h3F;

  localparam logic [31:0] ROM_PROBE = 32'hFFFF_FFFE;

  typedef struct packed {
    logic                cls;
    logic                lat;
    logic                intline;
    logic                cmd;
    logic                rom;
    logic [NUM_BARS-1:0] bar;
  } wr_sel_t;

  function automatic logic size_legal(input logic [2:0] s);
    return (s == 3'd1) || (s == 3'd2) || (s == 3'd4);
  endfunction

  function automatic logic offset_aligned(input logic [7:0] o, input logic [2:0] s);
    case (s)
      3'd2:    return ~o[0];
      3'd4:    return o[1:0] == 2'b00;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [31:0] bar_type_mask(input logic is_io);
    return is_io ? 32'h0000_0003 : 32'h0000_000F;
  endfunction

  function automatic logic [31:0] bar_probe_bits(input logic [31:0] sz);
    return ~(sz - 32'd1);
  endfunction

  function automatic logic [31:0] bar_merge(input logic [31:0] old_v,
                                            input logic [31:0] addr_v,
                                            input logic [31:0] mask);
    return (addr_v & ~mask) | (old_v & mask);
  endfunction

  function automatic logic bar_size_ok(input logic [31:0] sz);
    return (sz & (sz - 32'd1)) == 32'd0;
  endfunction

endpackage

// File: rtl/cfg_req_check.sv
module cfg_req_check
  import cfg_hdr_pkg::*;
(
  input  logic       write,
  input  logic [7:0] offset,
  input  logic [2:0] size,
  output logic       err,
  output wr_sel_t    sel
);

  logic range_bad, size_bad, align_bad;
  logic byte_store, byte_quiet, byte_bad, half_bad;
  logic [NUM_BARS-1:0] bar_hit;

  assign range_bad = offset >= HDR_LIMIT;
  assign size_bad  = !size_legal(size);
  assign align_bad = !offset_aligned(offset, size);

  assign byte_store = (offset == OFS_CLS) || (offset == OFS_LAT) ||
                      (offset == OFS_INTLINE);
  assign byte_quiet = (offset == OFS_REV) || (offset == OFS_CLASS) ||
                      (offset == OFS_INTPIN) || (offset == OFS_MINGNT) ||
                      (offset == OFS_MAXLAT);
  assign byte_bad   = write && (size == 3'd1) && !(byte_store || byte_quiet);
  assign half_bad   = write && (size == 3'd2) && (offset != OFS_CMD);

  assign err = range_bad || size_bad || align_bad || byte_bad || half_bad;

  for (genvar k = 0; k < NUM_BARS; k++) begin : g_bar_hit
    assign bar_hit[k] = offset == (OFS_BAR0 + 8'(4 * k));
  end

  always_comb begin
    sel = '0;
    if (write && !err) begin
      case (size)
        3'd1: begin
          sel.cls     = offset == OFS_CLS;
          sel.lat     = offset == OFS_LAT;
          sel.intline = offset == OFS_INTLINE;
        end
        3'd2: sel.cmd = 1'b1;
        3'd4: begin
          sel.cmd = offset == OFS_CMD;
          sel.rom = offset == OFS_ROM;
          sel.bar = bar_hit;
        end
        default: sel = '0;
      endcase
    end
  end

endmodule

// File: rtl/cfg_bar_slot.sv
module cfg_bar_slot
  import cfg_hdr_pkg::*;
#(
  parameter logic [31:0] SIZE       = 32'h0000_1000,
  parameter logic        IS_IO      = 1'b0,
  parameter logic [31:0] SPACE_BASE = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic [31:0] bar_q,
  output logic        en_q,
  output logic [31:0] base_q
);

  localparam logic [31:0] TYPE_MASK = bar_type_mask(IS_IO);
  localparam logic [31:0] TYPE_RST  = IS_IO ? 32'h0000_0001 : 32'h0000_0000;

  logic        probe;
  logic [31:0] addr_bits;
  logic        map_evt;

  assign probe     = wdata == 32'hFFFF_FFFF;
  assign addr_bits = wdata & ~TYPE_MASK;
  assign map_evt   = wr_en && !probe && (addr_bits != 32'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bar_q  <= TYPE_RST;
      en_q   <= 1'b0;
      base_q <= 32'd0;
    end else begin
      if (wr_en)
        bar_q <= bar_merge(bar_q, probe ? bar_probe_bits(SIZE) : wdata, TYPE_MASK);
      if (map_evt) begin
        en_q   <= 1'b1;
        base_q <= addr_bits + SPACE_BASE;
      end
    end
  end

endmodule

// File: rtl/cfg_header_regs.sv
module cfg_header_regs
  import cfg_hdr_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID     = 16'h1A2B,
  parameter logic [15:0] DEVICE_ID     = 16'h3C4D,
  parameter logic [15:0] CMD_INIT      = 16'h0000,
  parameter logic [15:0] STATUS_INIT   = 16'h0000,
  parameter logic [7:0]  REVISION      = 8'h00,
  parameter logic [7:0]  PROG_IF       = 8'h00,
  parameter logic [7:0]  SUBCLASS      = 8'h00,
  parameter logic [7:0]  CLASS_CODE    = 8'h02,
  parameter logic [7:0]  CLS_INIT      = 8'h00,
  parameter logic [7:0]  LAT_INIT      = 8'h00,
  parameter logic [7:0]  HDR_TYPE      = 8'h00,
  parameter logic [7:0]  BIST_VAL      = 8'h00,
  parameter logic [31:0] CIS_PTR       = 32'h0,
  parameter logic [15:0] SUBSYS_VENDOR = 16'h0000,
  parameter logic [15:0] SUBSYS_ID     = 16'h0000,
  parameter logic [31:0] ROM_INIT      = 32'h0,
  parameter logic [7:0]  INTLINE_INIT  = 8'h00,
  parameter logic [7:0]  INT_PIN       = 8'h01,
  parameter logic [7:0]  MIN_GNT       = 8'h00,
  parameter logic [7:0]  MAX_LAT       = 8'h00,
  parameter logic [NUM_BARS-1:0][31:0] BAR_SIZE =
    {32'h0001_0000, 32'h0000_0020, 32'h0010_0000,
     32'h0000_0000, 32'h0000_0100, 32'h0000_1000},
  parameter logic [NUM_BARS-1:0] BAR_IS_IO = 6'b010010,
  parameter logic [31:0] IO_BASE  = 32'h0001_0000,
  parameter logic [31:0] MEM_BASE = 32'h8000_0000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [7:0]               req_offset,
  input  logic [2:0]               req_size,
  input  logic [31:0]              req_wdata,
  output logic                     resp_valid,
  output logic [31:0]              resp_rdata,
  output logic                     resp_err,
  output logic [NUM_BARS-1:0]      bar_en_o,
  output logic [NUM_BARS*32-1:0]   bar_base_o
);

  // request events, brought out for the checker
  logic    acc;
  logic    acc_err;
  wr_sel_t dec_sel;
  wr_sel_t wr_sel;

  logic        resp_valid_q;
  logic        resp_err_q;
  logic [31:0] resp_rdata_q;

  logic [15:0] cmd_q;
  logic [7:0]  cls_q, lat_q, intline_q;
  logic [31:0] rom_q;
  logic [31:0] bar_val [NUM_BARS];

  logic [31:0] hdr_dw [HDR_DW];
  logic [31:0] rd_dw;
  logic [4:0]  byte_lsb, half_lsb;
  logic [31:0] rd_val;

  assign req_ready = !resp_valid_q;
  assign acc       = req_valid && req_ready;

  cfg_req_check u_check (
    .write  (req_write),
    .offset (req_offset),
    .size   (req_size),
    .err    (acc_err),
    .sel    (dec_sel)
  );

  assign wr_sel = acc ? dec_sel : '0;

  for (genvar k = 0; k < NUM_BARS; k++) begin : g_bar
    if (!bar_size_ok(BAR_SIZE[k])) begin : g_bad_size
      $error("BAR window size must be zero or a power of two");
    end
    cfg_bar_slot #(
      .SIZE       (BAR_SIZE[k]),
      .IS_IO      (BAR_IS_IO[k]),
      .SPACE_BASE (BAR_IS_IO[k] ? IO_BASE : MEM_BASE)
    ) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_sel.bar[k]),
      .wdata  (req_wdata),
      .bar_q  (bar_val[k]),
      .en_q   (bar_en_o[k]),
      .base_q (bar_base_o[32*k +: 32])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q     <= CMD_INIT;
      cls_q     <= CLS_INIT;
      lat_q     <= LAT_INIT;
      intline_q <= INTLINE_INIT;
      rom_q     <= ROM_INIT;
    end else begin
      if (wr_sel.cmd)     cmd_q     <= req_wdata[15:0];
      if (wr_sel.cls)     cls_q     <= req_wdata[7:0];
      if (wr_sel.lat)     lat_q     <= req_wdata[7:0];
      if (wr_sel.intline) intline_q <= req_wdata[7:0];
      if (wr_sel.rom)     rom_q     <= (req_wdata == ROM_PROBE) ? 32'hFFFF_FFFF : req_wdata;
    end
  end

  always_comb begin
    hdr_dw[0]  = {DEVICE_ID, VENDOR_ID};
    hdr_dw[1]  = {STATUS_INIT, cmd_q};
    hdr_dw[2]  = {CLASS_CODE, SUBCLASS, PROG_IF, REVISION};
    hdr_dw[3]  = {BIST_VAL, HDR_TYPE, lat_q, cls_q};
    for (int k = 0; k < NUM_BARS; k++) hdr_dw[4 + k] = bar_val[k];
    hdr_dw[10] = CIS_PTR;
    hdr_dw[11] = {SUBSYS_ID, SUBSYS_VENDOR};
    hdr_dw[12] = rom_q;
    hdr_dw[13] = 32'd0;
    hdr_dw[14] = 32'd0;
    hdr_dw[15] = {MAX_LAT, MIN_GNT, INT_PIN, intline_q};
  end

  assign rd_dw    = hdr_dw[req_offset[5:2]];
  assign byte_lsb = {req_offset[1:0], 3'b000};
  assign half_lsb = {req_offset[1], 4'b0000};

  always_comb begin
    case (req_size)
      3'd1:    rd_val = {24'd0, rd_dw[byte_lsb +: 8]};
      3'd2:    rd_val = {16'd0, rd_dw[half_lsb +: 16]};
      default: rd_val = rd_dw;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid_q <= 1'b0;
      resp_err_q   <= 1'b0;
      resp_rdata_q <= 32'd0;
    end else begin
      resp_valid_q <= acc;
      resp_err_q   <= acc && acc_err;
      if (acc)
        resp_rdata_q <= (acc_err || req_write) ? 32'd0 : rd_val;
    end
  end

  assign resp_valid = resp_valid_q;
  assign resp_err   = resp_err_q;
  assign resp_rdata = resp_rdata_q;

endmodule

// File: rtl/cfg_header_regs_chk.sv
module cfg_header_regs_chk
  import cfg_hdr_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic                   req_write,
  input logic [7:0]             req_offset,
  input logic [2:0]             req_size,
  input logic                   acc,
  input logic                   acc_err,
  input logic                   resp_valid,
  input logic                   resp_err,
  input logic [31:0]            resp_rdata,
  input logic [NUM_BARS-1:0]    bar_en,
  input logic [NUM_BARS*32-1:0] bar_base
);

  AST_RESP_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> resp_valid);  // R1

  AST_RESP_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !resp_valid);  // R1

  AST_NO_ACCEPT_WHILE_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !req_ready);  // R1

  AST_BAD_SIZE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !((req_size == 3'd1) || (req_size == 3'd2) || (req_size == 3'd4))) |=> resp_err);  // R3

  AST_ERR_KEEPS_BARS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && acc_err) |=> ($stable(bar_en) && $stable(bar_base)));  // R3

  AST_ERR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_err) |-> (resp_rdata == 32'd0));  // R3

  AST_RANGE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (req_offset >= HDR_LIMIT)) |=> resp_err);  // R4

  AST_READ_KEEPS_BARS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write) |=> ($stable(bar_en) && $stable(bar_base)));  // R5

  AST_ENABLE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((bar_en & $past(bar_en)) == $past(bar_en)));  // R11

endmodule

bind cfg_header_regs cfg_header_regs_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_write  (req_write),
  .req_offset (req_offset),
  .req_size   (req_size),
  .acc        (acc),
  .acc_err    (acc_err),
  .resp_valid (resp_valid),
  .resp_err   (resp_err),
  .resp_rdata (resp_rdata),
  .bar_en     (bar_en_o),
  .bar_base   (bar_base_o)
);

// File: tb/cfg_header_regs_test.sv
`timescale 1ns/1ps
module cfg_header_regs_test;

  localparam logic [15:0] T_VENDOR   = 16'hBEEF;
  localparam logic [15:0] T_DEVICE   = 16'h5A17;
  localparam logic [15:0] T_CMD      = 16'h0006;
  localparam logic [15:0] T_STATUS   = 16'h0290;
  localparam logic [7:0]  T_REV      = 8'h21;
  localparam logic [7:0]  T_PIF      = 8'h43;
  localparam logic [7:0]  T_SUB      = 8'h65;
  localparam logic [7:0]  T_CLASS    = 8'h87;
  localparam logic [7:0]  T_CLS      = 8'h10;
  localparam logic [7:0]  T_LAT      = 8'h20;
  localparam logic [7:0]  T_HDR      = 8'h80;
  localparam logic [7:0]  T_BIST     = 8'h0C;
  localparam logic [31:0] T_CIS      = 32'hC15C_0DE5;
  localparam logic [15:0] T_SVID     = 16'h7788;
  localparam logic [15:0] T_SID      = 16'h99AA;
  localparam logic [31:0] T_ROM      = 32'h000E_0000;
  localparam logic [7:0]  T_INTLINE  = 8'h0B;
  localparam logic [7:0]  T_INTPIN   = 8'h02;
  localparam logic [7:0]  T_MINGNT   = 8'h33;
  localparam logic [7:0]  T_MAXLAT   = 8'h44;
  localparam logic [5:0][31:0] T_SIZE =
    {32'h0001_0000, 32'h0000_0020, 32'h0010_0000,
     32'h0000_0000, 32'h0000_0100, 32'h0000_1000};
  localparam logic [5:0]  T_IO       = 6'b010010;
  localparam logic [31:0] T_IO_BASE  = 32'h0001_0000;
  localparam logic [31:0] T_MEM_BASE = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_offset = 8'd0;
  logic [2:0]  req_size = 3'd0;
  logic [31:0] req_wdata = 32'd0;
  logic        resp_valid;
  logic [31:0] resp_rdata;
  logic        resp_err;
  logic [5:0]  bar_en_o;
  logic [191:0] bar_base_o;

  always #2 clk = ~clk;

  cfg_header_regs #(
    .VENDOR_ID(T_VENDOR), .DEVICE_ID(T_DEVICE), .CMD_INIT(T_CMD),
    .STATUS_INIT(T_STATUS), .REVISION(T_REV), .PROG_IF(T_PIF),
    .SUBCLASS(T_SUB), .CLASS_CODE(T_CLASS), .CLS_INIT(T_CLS),
    .LAT_INIT(T_LAT), .HDR_TYPE(T_HDR), .BIST_VAL(T_BIST),
    .CIS_PTR(T_CIS), .SUBSYS_VENDOR(T_SVID), .SUBSYS_ID(T_SID),
    .ROM_INIT(T_ROM), .INTLINE_INIT(T_INTLINE), .INT_PIN(T_INTPIN),
    .MIN_GNT(T_MINGNT), .MAX_LAT(T_MAXLAT), .BAR_SIZE(T_SIZE),
    .BAR_IS_IO(T_IO), .IO_BASE(T_IO_BASE), .MEM_BASE(T_MEM_BASE)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_offset(req_offset), .req_size(req_size),
    .req_wdata(req_wdata), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .resp_err(resp_err), .bar_en_o(bar_en_o), .bar_base_o(bar_base_o)
  );

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  logic [7:0]  mdl [64];
  logic        mdl_en [6];
  logic [31:0] mdl_base [6];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mdl_dw(input int i);
    return {mdl[4*i+3], mdl[4*i+2], mdl[4*i+1], mdl[4*i]};
  endfunction

  task automatic set_dw(input int i, input logic [31:0] v);
    for (int b = 0; b < 4; b++) mdl[4*i+b] = v[8*b +: 8];
  endtask

  task automatic model_reset();
    for (int i = 0; i < 64; i++) mdl[i] = 8'h00;
    set_dw(0, {T_DEVICE, T_VENDOR});
    set_dw(1, {T_STATUS, T_CMD});
    set_dw(2, {T_CLASS, T_SUB, T_PIF, T_REV});
    set_dw(3, {T_BIST, T_HDR, T_LAT, T_CLS});
    for (int k = 0; k < 6; k++) begin
      set_dw(4 + k, T_IO[k] ? 32'h1 : 32'h0);
      mdl_en[k] = 1'b0;
      mdl_base[k] = 32'h0;
    end
    set_dw(10, T_CIS);
    set_dw(11, {T_SID, T_SVID});
    set_dw(12, T_ROM);
    set_dw(15, {T_MAXLAT, T_MINGNT, T_INTPIN, T_INTLINE});
  endtask

  function automatic logic exp_err(input logic w, input int off, input int sz);
    logic bad;
    bad = !(sz == 1 || sz == 2 || sz == 4) || off >= 64;
    if (sz == 2 && (off % 2) != 0) bad = 1'b1;
    if (sz == 4 && (off % 4) != 0) bad = 1'b1;
    if (w && sz == 1 && !(off == 12 || off == 13 || off == 60 ||
                          off == 8 || off == 11 || off == 61 || off == 62 || off == 63))
      bad = 1'b1;
    if (w && sz == 2 && off != 4) bad = 1'b1;
    return bad;
  endfunction

  function automatic logic [31:0] exp_read(input int off, input int sz);
    logic [31:0] v;
    v = 32'd0;
    for (int b = 0; b < sz; b++) v[8*b +: 8] = mdl[off + b];
    return v;
  endfunction

  task automatic model_write(input int off, input int sz, input logic [31:0] w);
    logic [31:0] msk, old, nv;
    int k;
    if (sz == 1 && (off == 12 || off == 13 || off == 60)) mdl[off] = w[7:0];
    if ((sz == 2 || sz == 4) && off == 4) begin
      mdl[4] = w[7:0];
      mdl[5] = w[15:8];
    end
    if (sz == 4 && off >= 16 && off <= 36) begin
      k = (off - 16) / 4;
      msk = T_IO[k] ? 32'h3 : 32'hF;
      old = mdl_dw(4 + k);
      nv = (w == 32'hFFFF_FFFF) ? (32'd0 - T_SIZE[k]) : w;
      set_dw(4 + k, (nv & ~msk) | (old & msk));
      if (w != 32'hFFFF_FFFF && (w & ~msk) != 0) begin
        mdl_en[k] = 1'b1;
        mdl_base[k] = (w & ~msk) + (T_IO[k] ? T_IO_BASE : T_MEM_BASE);
      end
    end
    if (sz == 4 && off == 48) set_dw(12, (w == 32'hFFFF_FFFE) ? 32'hFFFF_FFFF : w);
  endtask

  // one request; checks the handshake timing on the way (R1)
  task automatic xfer(input logic w, input logic [7:0] off, input logic [2:0] sz,
                      input logic [31:0] wd, output logic [31:0] rd, output logic er);
    @(negedge clk);
    chk("R1 idle resp_valid", {31'd0, resp_valid}, 32'd0);
    chk("R1 ready when idle", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_write = w; req_offset = off; req_size = sz; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 resp pulse", {31'd0, resp_valid}, 32'd1);
    chk("R1 ready low during resp", {31'd0, req_ready}, 32'd0);
    rd = resp_rdata;
    er = resp_err;
  endtask

  task automatic do_write(input string tag, input int off, input int sz, input logic [31:0] w);
    logic [31:0] rd;
    logic er, ee;
    ee = exp_err(1'b1, off, sz);
    xfer(1'b1, 8'(off), 3'(sz), w, rd, er);
    chk(tag, {31'd0, er}, {31'd0, ee});
    chk({tag, " write data"}, rd, 32'd0);
    if (!ee) model_write(off, sz, w);
  endtask

  task automatic check_exports(input string tag);
    for (int k = 0; k < 6; k++) begin
      chk({tag, " R11 enable"}, {31'd0, bar_en_o[k]}, {31'd0, mdl_en[k]});
      chk({tag, " R11 base"}, bar_base_o[32*k +: 32], mdl_base[k]);
    end
  endtask

  task automatic full_readback(input string tag);
    logic [31:0] rd;
    logic er;
    for (int off = 0; off < 64; off++) begin
      for (int sz = 1; sz <= 4; sz = sz * 2) begin
        if ((off % sz) == 0) begin
          xfer(1'b0, 8'(off), 3'(sz), 32'h0, rd, er);
          chk({tag, " R5 read err"}, {31'd0, er}, 32'd0);
          chk({tag, " R5 read data"}, rd, exp_read(off, sz));
        end
      end
    end
    check_exports(tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  initial begin
    logic [31:0] rd;
    logic er;

    do_reset();
    check_exports("R2 after reset");
    full_readback("R2 reset values");

    // read sweep over offsets and all size codes
    for (int off = 0; off < 72; off++) begin
      for (int sz = 0; sz < 8; sz++) begin
        xfer(1'b0, 8'(off), 3'(sz), 32'h0, rd, er);
        chk("R3 R4 read sweep err", {31'd0, er}, {31'd0, exp_err(1'b0, off, sz)});
        chk("R3 R4 read sweep data", rd, exp_err(1'b0, off, sz) ? 32'd0 : exp_read(off, sz));
      end
    end
    xfer(1'b0, 8'hFF, 3'd1, 32'h0, rd, er);
    chk("R4 offset 0xFF", {31'd0, er}, 32'd1);

    // illegal sizes at a BAR and at the command register
    for (int sz = 0; sz < 8; sz++) begin
      if (!(sz == 1 || sz == 2 || sz == 4)) begin
        do_write("R3 bad size to BAR0", 16, sz, 32'h1234_5000);
        do_write("R3 bad size to command", 4, sz, 32'h0000_FFFF);
      end
    end
    do_write("R4 misaligned dword to BAR1", 22, 4, 32'h0000_5500);
    do_write("R4 above header", 64, 4, 32'h0000_5500);
    full_readback("R3 R4 nothing changed");

    // byte writes everywhere
    for (int off = 0; off < 64; off++)
      do_write("R6 byte write err", off, 1, 32'hA500 | 32'(off ^ 8'h5A));
    full_readback("R6 byte effects");

    // halfword writes everywhere
    for (int off = 0; off < 64; off += 2)
      do_write("R7 half write err", off, 2, 32'hC300 + 32'(off));
    full_readback("R7 half effects");

    // dword writes to every non-BAR dword
    for (int off = 0; off < 64; off += 4)
      if (off < 16 || off > 36)
        do_write("R8 dword write err", off, 4, 32'h9E37_0000 | 32'(off));
    full_readback("R8 R12 dword effects");

    // ROM probe value and its neighbours
    do_write("R12 rom probe", 48, 4, 32'hFFFF_FFFE);
    xfer(1'b0, 8'h30, 3'd4, 32'h0, rd, er);
    chk("R12 rom reads all ones", rd, 32'hFFFF_FFFF);
    do_write("R12 rom near probe", 48, 4, 32'h7FFF_FFFE);
    xfer(1'b0, 8'h30, 3'd4, 32'h0, rd, er);
    chk("R12 rom stored as written", rd, 32'h7FFF_FFFE);
    do_write("R12 rom other neighbour", 48, 4, 32'hFFFF_FFFC);
    xfer(1'b0, 8'h30, 3'd4, 32'h0, rd, er);
    chk("R12 rom stored as written 2", rd, 32'hFFFF_FFFC);

    // sizing probe on every BAR
    for (int k = 0; k < 6; k++) begin
      do_write("R9 probe", 16 + 4 * k, 4, 32'hFFFF_FFFF);
      xfer(1'b0, 8'(16 + 4 * k), 3'd4, 32'h0, rd, er);
      chk("R9 probe readback", rd, mdl_dw(4 + k));
      chk("R9 probe arithmetic", rd,
          (32'd0 - T_SIZE[k]) & ~(T_IO[k] ? 32'h3 : 32'hF) | (T_IO[k] ? 32'h1 : 32'h0));
    end
    check_exports("R9 probe keeps enables");

    // map every BAR with a value that also tries to flip type bits
    for (int k = 0; k < 6; k++)
      do_write("R10 map", 16 + 4 * k, 4, 32'h0123_400F + 32'(k << 16));
    full_readback("R10 R11 mapped");

    // zero write and probe on a mapped BAR keep enable and base
    do_write("R11 zero write", 16, 4, 32'h0000_0000);
    do_write("R11 type-only write", 20, 4, 32'h0000_0002);
    do_write("R11 probe after map", 24, 4, 32'hFFFF_FFFF);
    full_readback("R11 sticky");
    do_write("R11 remap", 16, 4, 32'hFEDC_B000);
    check_exports("R11 remap");

    // reset again restores defaults
    do_reset();
    check_exports("R2 second reset");
    full_readback("R2 second reset");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule